// File: doc/BRIEF.md
# Four-Thread Windowed Integer Register File

This block is the integer register file for a core that interleaves four hardware threads. Each thread owns a stack of register windows. At any time one window per thread is active. The active window is reached through three read ports and two write ports. Every port carries a thread tag, so one cycle can mix accesses from different threads.

Moving a thread to its next window (save) or back to its previous window (restore) is a swap with a fixed latency. Swaps from different threads share a short pipeline, so a new swap can enter every cycle while earlier ones are still moving. A swap stalls only its own thread. That thread's requests and port accesses are refused until its swap-done strobe, and the other threads keep running at full rate. The windowed register space of a thread is `NWIN` windows of `NREG` registers, each `DW` bits wide.

Top module: `thread_window_rf`

## Requirements
- R1: After reset every register of every window of every thread reads as zero, every `cur_win` field is 0, `busy` is all zero and `sw_done` is low.
- R2: A read port with `rd_en` high, on a thread that is not busy, returns in the next cycle `rd_ok`=1 and the register `rd_addr` of the thread's current window. All three ports work in the same cycle on any mix of threads.
- R3: A write port with `wr_en` high, on a thread that is not busy, stores `wr_data` into register `wr_addr` of that thread's current window. A read of the same register in the same cycle returns the old value, and later reads return the new one.
- R4: When both write ports hit the same register of the same thread and window in one cycle, the value on write port 0 is stored.
- R5: Threads hold separate storage: a write tagged with one thread never changes what another thread reads.
- R6: A swap accepted in cycle n (`sw_req`=1 and `sw_ack`=1) raises `sw_done` for exactly one cycle in cycle n+3, with `sw_done_tid` equal to the accepted thread. `sw_ack` is combinational and is high exactly when `sw_req` is high and the requested thread is not busy.
- R7: Swaps on different threads are accepted in consecutive cycles with no gap, and their done strobes follow on consecutive cycles.
- R8: A thread with a swap in flight has `busy` high in cycles n+1 and n+2. A request on that thread is not acknowledged before cycle n+3, and requests on other threads are unaffected.
- R9: A read on a busy thread gives `rd_ok`=0 and zero data in the next cycle. A write on a busy thread is dropped.
- R10: A save (`sw_save`=1) advances the thread's `cur_win` by one, and a restore (`sw_save`=0) moves it back by one. The change takes effect in the cycle in which `sw_done` is high. Each window keeps its own register contents across swaps.
- R11: The window number wraps modulo `NWIN`: after `NWIN` saves a thread is back in window 0 and sees that window's contents again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | NRD | Read enable per read port |
| rd_tid | input | NRD*TW | Thread tag per read port, port p at [p*TW +: TW] |
| rd_addr | input | NRD*AW | Register index per read port |
| rd_data | output | NRD*DW | Read data, one cycle after the request |
| rd_ok | output | NRD | Read was served (thread not busy) |
| wr_en | input | NWR | Write enable per write port |
| wr_tid | input | NWR*TW | Thread tag per write port |
| wr_addr | input | NWR*AW | Register index per write port |
| wr_data | input | NWR*DW | Write data per write port |
| sw_req | input | 1 | Swap request, held until acknowledged |
| sw_tid | input | TW | Thread of the swap request |
| sw_save | input | 1 | 1 = save (next window), 0 = restore (previous window) |
| sw_ack | output | 1 | Swap accepted this cycle |
| sw_done | output | 1 | One-cycle strobe when a swap completes |
| sw_done_tid | output | TW | Thread whose swap completed |
| busy | output | NTHR | Per-thread swap-in-flight flags |
| cur_win | output | NTHR*WW | Current window of each thread |

## Verification
The bench goes after the cycles around a swap. A read or write issued in the two cycles a swap is in flight must be refused. A design that checked only the first pipeline stage would let the last cycle's write land in the old window. In the cycle of the done strobe, accesses must already see the new window, so an off-by-one in the latency shows up as data read from the wrong window. Two back-to-back requests on one thread must be held apart while other threads flow on every cycle, which exposes a global stall or a missing per-thread interlock. Same-register writes on both ports, read-during-write and the wrap after eight saves catch a reversed port priority, a bypassed read and a pointer that saturates instead of wrapping.

// File: rtl/twrf_pkg.sv
package twrf_pkg;
  // Direction of a window swap as carried through the swap pipeline.
  typedef enum logic {
    DIR_RESTORE = 1'b0,
    DIR_SAVE    = 1'b1
  } swap_dir_e;
endpackage

// File: rtl/twrf_swap_pipe.sv
// Swap pipeline: two stage registers plus the completion step, per-thread
// busy tracking and the current-window pointers.
module twrf_swap_pipe
  import twrf_pkg::*;
#(
  parameter int NTHR = 4,
  parameter int NWIN = 8,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic [TW-1:0]    sw_tid,
  input  logic             sw_save,
  output logic             sw_ack,
  output logic             sw_done,
  output logic [TW-1:0]    sw_done_tid,
  output logic [NTHR-1:0]  busy,
  output logic [NTHR*WW-1:0] cwp_flat
);

  logic          s0_v_q, s1_v_q, s0_v_n;
  logic [TW-1:0] s0_t_q, s1_t_q;
  swap_dir_e     s0_d_q, s1_d_q;
  logic          done_q;
  logic [TW-1:0] done_t_q;
  logic [WW-1:0] cwp_q [NTHR];
  logic [WW-1:0] cwp_n [NTHR];
  logic [NTHR-1:0] cwp_en;

  // A thread is busy while its swap sits in either stage.
  for (genvar t = 0; t < NTHR; t++) begin : g_busy
    assign busy[t] = (s0_v_q && s0_t_q == TW'(t)) || (s1_v_q && s1_t_q == TW'(t));
    assign cwp_flat[t*WW +: WW] = cwp_q[t];
    assign cwp_en[t] = s1_v_q && (s1_t_q == TW'(t));
    assign cwp_n[t]  = (s1_d_q == DIR_SAVE) ? cwp_q[t] + WW'(1) : cwp_q[t] - WW'(1);
  end

  assign sw_ack = sw_req && !busy[sw_tid];
  assign s0_v_n = sw_ack;
  assign sw_done = done_q;
  assign sw_done_tid = done_t_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_v_q   <= 1'b0;
      s1_v_q   <= 1'b0;
      s0_t_q   <= '0;
      s1_t_q   <= '0;
      s0_d_q   <= DIR_RESTORE;
      s1_d_q   <= DIR_RESTORE;
      done_q   <= 1'b0;
      done_t_q <= '0;
    end else begin
      s0_v_q <= s0_v_n;
      s1_v_q <= s0_v_q;
      done_q <= s1_v_q;
      if (s0_v_n) begin
        s0_t_q <= sw_tid;
        s0_d_q <= swap_dir_e'(sw_save);
      end
      if (s0_v_q) begin
        s1_t_q <= s0_t_q;
        s1_d_q <= s0_d_q;
      end
      if (s1_v_q) done_t_q <= s1_t_q;
    end
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_cwp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cwp_q[t] <= '0;
      else if (cwp_en[t]) cwp_q[t] <= cwp_n[t];
    end

    // R10: the window moves only in the cycle its thread's done strobe is high.
    p_win_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_done && sw_done_tid == TW'(t)) |-> (cwp_q[t] != $past(cwp_q[t])));
    p_win_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sw_done && sw_done_tid == TW'(t)) |-> $stable(cwp_q[t]));
  end

  // R8: never two swaps of one thread in flight together.
  p_one_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(s0_v_q && s1_v_q && s0_t_q == s1_t_q));
  // R8: an accepted thread reads busy in the next cycle.
  p_busy_after_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ack |=> busy[$past(sw_tid)]);

endmodule

// File: rtl/twrf_store.sv
// Windowed storage for all threads with tagged read and write ports.
module twrf_store #(
  parameter int NTHR = 4,
  parameter int NWIN = 8,
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  parameter int NWR  = 2,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NRD-1:0]     rd_en,
  input  logic [NRD*TW-1:0]  rd_tid,
  input  logic [NRD*AW-1:0]  rd_addr,
  output logic [NRD*DW-1:0]  rd_data,
  output logic [NRD-1:0]     rd_ok,
  input  logic [NWR-1:0]     wr_en,
  input  logic [NWR*TW-1:0]  wr_tid,
  input  logic [NWR*AW-1:0]  wr_addr,
  input  logic [NWR*DW-1:0]  wr_data,
  input  logic [NTHR-1:0]    busy,
  input  logic [NTHR*WW-1:0] cwp_flat
);

  logic [DW-1:0] mem_q [NTHR][NWIN][NREG];
  logic [WW-1:0] win [NTHR];

  logic [NWR-1:0] wgo;
  logic [TW-1:0]  wt [NWR];
  logic [WW-1:0]  wwin [NWR];
  logic [AW-1:0]  wa [NWR];
  logic [DW-1:0]  wd [NWR];

  logic [NRD-1:0] rgo;
  logic [TW-1:0]  rt [NRD];
  logic [AW-1:0]  ra [NRD];
  logic [DW-1:0]  rdat_n [NRD];
  logic [DW-1:0]  rdat_q [NRD];
  logic [NRD-1:0] rok_q;

  for (genvar t = 0; t < NTHR; t++) begin : g_win
    assign win[t] = cwp_flat[t*WW +: WW];
  end

  for (genvar p = 0; p < NWR; p++) begin : g_wr
    assign wt[p]   = wr_tid[p*TW +: TW];
    assign wa[p]   = wr_addr[p*AW +: AW];
    assign wd[p]   = wr_data[p*DW +: DW];
    assign wwin[p] = win[wt[p]];
    assign wgo[p]  = wr_en[p] && !busy[wt[p]];
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rt[p]     = rd_tid[p*TW +: TW];
    assign ra[p]     = rd_addr[p*AW +: AW];
    assign rgo[p]    = rd_en[p] && !busy[rt[p]];
    assign rdat_n[p] = rgo[p] ? mem_q[rt[p]][win[rt[p]]][ra[p]] : '0;
    assign rd_data[p*DW +: DW] = rdat_q[p];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdat_q[p] <= '0;
      else        rdat_q[p] <= rdat_n[p];
    end
  end

  assign rd_ok = rok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rok_q <= '0;
    else        rok_q <= rgo;
  end

  // Higher-numbered ports are applied first so that port 0 wins a collision.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++)
        for (int w = 0; w < NWIN; w++)
          for (int r = 0; r < NREG; r++)
            mem_q[t][w][r] <= '0;
    end else begin
      for (int p = NWR - 1; p >= 0; p--)
        if (wgo[p]) mem_q[wt[p]][wwin[p]][wa[p]] <= wd[p];
    end
  end

endmodule

// File: rtl/thread_window_rf.sv
// Top: four-thread windowed integer register file with pipelined swaps.
module thread_window_rf #(
  parameter int NTHR = 4,
  parameter int NWIN = 8,
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NRD  = 3,
  parameter int NWR  = 2,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1,
  localparam int WW = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NRD-1:0]     rd_en,
  input  logic [NRD*TW-1:0]  rd_tid,
  input  logic [NRD*AW-1:0]  rd_addr,
  output logic [NRD*DW-1:0]  rd_data,
  output logic [NRD-1:0]     rd_ok,
  input  logic [NWR-1:0]     wr_en,
  input  logic [NWR*TW-1:0]  wr_tid,
  input  logic [NWR*AW-1:0]  wr_addr,
  input  logic [NWR*DW-1:0]  wr_data,
  input  logic               sw_req,
  input  logic [TW-1:0]      sw_tid,
  input  logic               sw_save,
  output logic               sw_ack,
  output logic               sw_done,
  output logic [TW-1:0]      sw_done_tid,
  output logic [NTHR-1:0]    busy,
  output logic [NTHR*WW-1:0] cur_win
);

  twrf_swap_pipe #(.NTHR(NTHR), .NWIN(NWIN)) u_swap (
    .clk         (clk),
    .rst_n       (rst_n),
    .sw_req      (sw_req),
    .sw_tid      (sw_tid),
    .sw_save     (sw_save),
    .sw_ack      (sw_ack),
    .sw_done     (sw_done),
    .sw_done_tid (sw_done_tid),
    .busy        (busy),
    .cwp_flat    (cur_win)
  );

  twrf_store #(
    .NTHR(NTHR), .NWIN(NWIN), .NREG(NREG), .DW(DW), .NRD(NRD), .NWR(NWR)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_tid   (rd_tid),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .rd_ok    (rd_ok),
    .wr_en    (wr_en),
    .wr_tid   (wr_tid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .busy     (busy),
    .cwp_flat (cur_win)
  );

  // R6: completion lands exactly three cycles after acceptance, same thread.
  p_done_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> $past(sw_ack, 3));
  p_done_tid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sw_done |-> (sw_done_tid == $past(sw_tid, 3)));

  for (genvar p = 0; p < NRD; p++) begin : g_rd_chk
    // R9: a served read never came from a busy thread; a refused one is zero.
    p_rd_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ok[p] |-> ($past(rd_en[p]) && !$past(busy[rd_tid[p*TW +: TW]])));
    p_rd_refused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_ok[p] |-> (rd_data[p*DW +: DW] == '0));
  end

endmodule

// File: tb/thread_window_rf_bench.sv
module thread_window_rf_bench;
  localparam int NTHR = 4, NWIN = 8, NREG = 32, DW = 32, NRD = 3, NWR = 2;
  localparam int TW = 2, WW = 3, AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NRD-1:0]     rd_en;
  logic [NRD*TW-1:0]  rd_tid;
  logic [NRD*AW-1:0]  rd_addr;
  logic [NRD*DW-1:0]  rd_data;
  logic [NRD-1:0]     rd_ok;
  logic [NWR-1:0]     wr_en;
  logic [NWR*TW-1:0]  wr_tid;
  logic [NWR*AW-1:0]  wr_addr;
  logic [NWR*DW-1:0]  wr_data;
  logic               sw_req, sw_save, sw_ack, sw_done;
  logic [TW-1:0]      sw_tid, sw_done_tid;
  logic [NTHR-1:0]    busy;
  logic [NTHR*WW-1:0] cur_win;

  thread_window_rf u_thread_window_rf (.*);

  // Stimulus fields
  logic          b_ren [NRD];
  logic [TW-1:0] b_rt  [NRD];
  logic [AW-1:0] b_ra  [NRD];
  logic          b_wen [NWR];
  logic [TW-1:0] b_wt  [NWR];
  logic [AW-1:0] b_wa  [NWR];
  logic [DW-1:0] b_wd  [NWR];

  always_comb begin
    for (int p = 0; p < NRD; p++) begin
      rd_en[p] = b_ren[p];
      rd_tid[p*TW +: TW] = b_rt[p];
      rd_addr[p*AW +: AW] = b_ra[p];
    end
    for (int p = 0; p < NWR; p++) begin
      wr_en[p] = b_wen[p];
      wr_tid[p*TW +: TW] = b_wt[p];
      wr_addr[p*AW +: AW] = b_wa[p];
      wr_data[p*DW +: DW] = b_wd[p];
    end
  end

  // Behavioural reference model
  logic [DW-1:0] mm [NTHR][NWIN][NREG];
  int  m_win [NTHR];
  bit  m_fly [NTHR];
  int  m_age [NTHR];
  bit  m_dir [NTHR];

  int nchk = 0, nerr = 0;
  bit finished = 0;
  string cur_req = "R1";
  logic last_ack;
  logic [DW-1:0] rd_snap [NRD];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    for (int p = 0; p < NRD; p++) begin b_ren[p] = 0; b_rt[p] = 0; b_ra[p] = 0; end
    for (int p = 0; p < NWR; p++) begin b_wen[p] = 0; b_wt[p] = 0; b_wa[p] = 0; b_wd[p] = 0; end
    sw_req = 0; sw_tid = 0; sw_save = 0;
  endtask

  // One clock: check combinational outputs, advance the model, compare after the edge.
  task automatic tick();
    bit exp_ack, exp_done;
    int exp_dt;
    bit exp_ok [NRD];
    logic [DW-1:0] exp_d [NRD];
    logic [NTHR-1:0] exp_busy;
    #1;
    for (int t = 0; t < NTHR; t++) exp_busy[t] = m_fly[t];
    check(busy == exp_busy, "R8", "busy", busy, exp_busy);
    exp_ack = sw_req && !m_fly[sw_tid];
    check(sw_ack == exp_ack, cur_req, "sw_ack", sw_ack, exp_ack);
    last_ack = sw_ack;
    for (int p = 0; p < NRD; p++) begin
      exp_ok[p] = b_ren[p] && !m_fly[b_rt[p]];
      exp_d[p]  = exp_ok[p] ? mm[b_rt[p]][m_win[b_rt[p]]][b_ra[p]] : '0;
    end
    for (int p = NWR - 1; p >= 0; p--)
      if (b_wen[p] && !m_fly[b_wt[p]]) mm[b_wt[p]][m_win[b_wt[p]]][b_wa[p]] = b_wd[p];
    exp_done = 0; exp_dt = 0;
    for (int t = 0; t < NTHR; t++)
      if (m_fly[t]) begin
        if (m_age[t] == 1) begin
          m_win[t] = m_dir[t] ? (m_win[t] + 1) % NWIN : (m_win[t] + NWIN - 1) % NWIN;
          m_fly[t] = 0; exp_done = 1; exp_dt = t;
        end else m_age[t] = 1;
      end
    if (exp_ack) begin
      m_fly[sw_tid] = 1; m_age[sw_tid] = 0; m_dir[sw_tid] = sw_save;
    end
    @(posedge clk);
    #2;
    for (int p = 0; p < NRD; p++) begin
      check(rd_ok[p] == exp_ok[p], cur_req, $sformatf("rd_ok[%0d]", p), rd_ok[p], exp_ok[p]);
      check(rd_data[p*DW +: DW] == exp_d[p], cur_req, $sformatf("rd_data[%0d]", p),
            rd_data[p*DW +: DW], exp_d[p]);
      rd_snap[p] = rd_data[p*DW +: DW];
    end
    check(sw_done == exp_done, "R6", "sw_done", sw_done, exp_done);
    if (exp_done) check(sw_done_tid == TW'(exp_dt), "R6", "sw_done_tid", sw_done_tid, exp_dt);
    for (int t = 0; t < NTHR; t++)
      check(cur_win[t*WW +: WW] == WW'(m_win[t]), "R10", $sformatf("cur_win[%0d]", t),
            cur_win[t*WW +: WW], m_win[t]);
  endtask

  task automatic wr(input int port, input int t, input int a, input logic [DW-1:0] d);
    b_wen[port] = 1; b_wt[port] = TW'(t); b_wa[port] = AW'(a); b_wd[port] = d;
  endtask

  task automatic rd(input int port, input int t, input int a);
    b_ren[port] = 1; b_rt[port] = TW'(t); b_ra[port] = AW'(a);
  endtask

  // Hold a swap request until acknowledged; return cycles waited.
  task automatic swap_wait(input int t, input bit save, output int waited);
    waited = 0;
    sw_req = 1; sw_tid = TW'(t); sw_save = save;
    tick();
    while (!last_ack && waited < 20) begin waited++; tick(); end
    sw_req = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int w;
    for (int t = 0; t < NTHR; t++) begin
      m_win[t] = 0; m_fly[t] = 0; m_age[t] = 0; m_dir[t] = 0;
      for (int v = 0; v < NWIN; v++) for (int r = 0; r < NREG; r++) mm[t][v][r] = '0;
    end
    idle();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state
    check(busy == '0, "R1", "busy after reset", busy, 0);
    check(cur_win == '0, "R1", "cur_win after reset", cur_win, 0);
    check(sw_done == 1'b0, "R1", "sw_done after reset", sw_done, 0);
    check(rd_ok == '0, "R1", "rd_ok after reset", rd_ok, 0);
    cur_req = "R1";
    for (int t = 0; t < NTHR; t++)
      for (int r = 0; r < NREG; r += 3) begin
        idle(); rd(0, t, r); rd(1, t, r + 1); rd(2, t, (r + 2) % NREG); tick();
      end

    // R2, R3: two writes, then three reads; read-during-write returns old value
    cur_req = "R3";
    idle(); wr(0, 0, 5, 32'hA5A5_0005); wr(1, 0, 9, 32'h0000_0909); rd(0, 0, 5); tick();
    check(rd_snap[0] == '0, "R3", "read during write old value", rd_snap[0], 0);
    cur_req = "R2";
    idle(); rd(0, 0, 5); rd(1, 0, 9); rd(2, 1, 5); tick();
    check(rd_snap[0] == 32'hA5A5_0005, "R2", "port0 data", rd_snap[0], 32'hA5A5_0005);
    check(rd_snap[1] == 32'h0000_0909, "R2", "port1 data", rd_snap[1], 32'h0000_0909);

    // R5: same register on another thread
    cur_req = "R5";
    idle(); wr(0, 1, 5, 32'h1111_1111); tick();
    idle(); rd(0, 0, 5); rd(1, 1, 5); tick();
    check(rd_snap[0] == 32'hA5A5_0005, "R5", "thread0 untouched", rd_snap[0], 32'hA5A5_0005);
    check(rd_snap[1] == 32'h1111_1111, "R5", "thread1 own value", rd_snap[1], 32'h1111_1111);

    // R4: collision between write ports
    cur_req = "R4";
    idle(); wr(0, 2, 7, 32'hC0C0_0000); wr(1, 2, 7, 32'hD1D1_1111); tick();
    idle(); rd(2, 2, 7); tick();
    check(rd_snap[2] == 32'hC0C0_0000, "R4", "port0 wins", rd_snap[2], 32'hC0C0_0000);

    // R6, R9, R10: save on thread 0, access it while busy
    cur_req = "R9";
    idle(); sw_req = 1; sw_tid = 0; sw_save = 1; tick();
    check(last_ack == 1'b1, "R6", "save accepted", last_ack, 1);
    idle(); rd(0, 0, 5); wr(0, 0, 5, 32'hDEAD_0001); tick();
    check(rd_ok[0] == 1'b0, "R9", "read refused while busy", rd_ok[0], 0);
    idle(); wr(1, 0, 9, 32'hDEAD_0002); rd(1, 1, 5); tick();
    check(rd_ok[1] == 1'b1, "R8", "other thread served", rd_ok[1], 1);
    check(sw_done == 1'b1, "R6", "done three cycles after accept", sw_done, 1);
    cur_req = "R10";
    idle(); rd(0, 0, 5); rd(1, 0, 9); tick();
    check(rd_snap[0] == '0, "R10", "new window empty", rd_snap[0], 0);
    idle(); wr(0, 0, 5, 32'hBEEF_0010); tick();
    idle(); sw_req = 1; sw_tid = 0; sw_save = 0; tick();
    idle(); tick(); tick();
    idle(); rd(0, 0, 5); rd(1, 0, 9); tick();
    check(rd_snap[0] == 32'hA5A5_0005, "R10", "restore shows old window", rd_snap[0], 32'hA5A5_0005);
    check(rd_snap[1] == 32'h0000_0909, "R9", "busy write dropped", rd_snap[1], 32'h0000_0909);

    // R7: back-to-back swaps on four threads
    cur_req = "R7";
    for (int t = 0; t < NTHR; t++) begin
      idle(); sw_req = 1; sw_tid = TW'(t); sw_save = 1; tick();
      check(last_ack == 1'b1, "R7", $sformatf("ack thread %0d", t), last_ack, 1);
    end
    idle(); repeat (4) tick();

    // R8: second swap on the same thread waits until the done cycle
    cur_req = "R8";
    idle(); swap_wait(1, 0, w);
    swap_wait(1, 0, w);
    check(w == 2, "R8", "cycles refused before second ack", w, 2);
    idle(); repeat (3) tick();

    // R11: wrap after NWIN saves
    cur_req = "R11";
    idle(); wr(0, 3, 12, 32'h7777_0012); tick();
    for (int k = 0; k < NWIN; k++) begin idle(); swap_wait(3, 1, w); end
    idle(); repeat (3) tick();
    check(cur_win[3*WW +: WW] == WW'(m_win[3]), "R11", "window after wrap", cur_win[3*WW +: WW], m_win[3]);
    idle(); rd(0, 3, 12); tick();
    check(rd_snap[0] == 32'h7777_0012, "R11", "wrapped window data", rd_snap[0], 32'h7777_0012);

    // Mixed traffic against the model
    cur_req = "R2";
    for (int k = 0; k < 600; k++) begin
      idle();
      for (int p = 0; p < NRD; p++) if ($urandom_range(3) != 0) rd(p, $urandom_range(3), $urandom_range(NREG - 1));
      for (int p = 0; p < NWR; p++) if ($urandom_range(2) != 0) wr(p, $urandom_range(3), $urandom_range(7), $urandom);
      if ($urandom_range(2) == 0) begin sw_req = 1; sw_tid = TW'($urandom_range(3)); sw_save = $urandom_range(1) != 0; end
      tick();
    end
    idle(); repeat (4) tick();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule